// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Burst SRAM

A single-clock synchronous SRAM with a small on-chip array (256 words of 18 bits by default, split into two 9-bit byte lanes). Address, control and byte enables are registered on the rising clock edge. A registered read presents its word during the very next cycle, straight from the array without an output register. A registered write takes its data one enabled edge later. Because both directions are aligned this way, a read can follow a write (or a write a read) on consecutive cycles with no idle slot.

Each transfer either loads a fresh external address or advances a 2-bit beat counter. Advancing moves through a four-word group in linear order (adding the count) or in interleaved order (XOR-ing the count). The order is chosen at load time. An active-low clock enable freezes the whole block. The block is selected only when all three chip selects are active. The shared data bus is modelled as a separate read-data output with a valid flag; the flag low stands for the tri-stated bus.

Top module: `nws_sram`

## Requirements
- R1: While and after reset with no transfer loaded, `rdata_vld` is 0 and `rdata` is 0.
- R2: An enabled edge with `advance`=0, all selects active (`sel0_n`=0, `sel1`=1, `sel2_n`=0) and `wr_n`=1 loads a read: during the next cycle `rdata_vld`=1 and `rdata` equals the stored word at `addr`.
- R3: A load with `wr_n`=0 starts a write. The data on `wdata` at the following enabled edge is stored at the beat address. Lane i (bits [9i+8:9i]) is written only if `lane_wr_n[i]`=0, as sampled at the edge that registered that beat.
- R4: A load with any select inactive is a deselect: no word is written and `rdata_vld` stays 0. Advancing after a deselect remains deselected.
- R5: An enabled edge with `advance`=1 continues the previous operation (read, write or deselect) at the next beat, with the beat count incremented modulo 4 and the address upper bits unchanged.
- R6: With `burst_il`=0 at load, beat k uses the low two address bits (a+k) mod 4.
- R7: With `burst_il`=1 at load, beat k uses the low two address bits a XOR k.
- R8: An edge with `clk_en_n`=1 ignores every input. No word is written, no write data is captured, and `rdata`/`rdata_vld` hold their previous values.
- R9: Reads and writes may alternate on every consecutive enabled edge with no idle cycle, and each transfer completes correctly.
- R10: A read loaded on the edge directly after a write load to the same address returns the newly written data.
- R11: `rdata_vld` is 0 in every cycle that carries a write or a deselect, and `rdata` is then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| advance | input | 1 | 0 loads a new address and operation, 1 advances the beat |
| wr_n | input | 1 | 0 = write, 1 = read at load |
| lane_wr_n | input | 2 | Per-lane active-low write enables |
| burst_il | input | 1 | Beat order at load: 1 interleaved, 0 linear |
| addr | input | 8 | Word address |
| wdata | input | 18 | Write data, taken one enabled edge after its beat |
| rdata | output | 18 | Read data, 0 when not valid |
| rdata_vld | output | 1 | Read data is driven (bus not tri-stated) |

## Verification
A wrong beat counter or a wrong order decode shows up in the first cycle of a burst whose beat address differs: `rdata` returns a neighbouring word of the group. A corrupted operation register shows up in the next cycle as a wrong `rdata_vld` level. A write that lands on the wrong address or lane, or at the wrong edge, becomes visible at the first later read of that word. This is why every word is first filled with known data and reads then follow writes closely. Stall errors show up as outputs that change during frozen cycles, or as write data taken from the wrong cycle.

// File: rtl/nws_pkg.sv
package nws_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // Low two address bits of a beat: interleaved XORs, linear adds mod 4.
  function automatic logic [1:0] beat_lsb(input logic [1:0] start,
                                          input logic [1:0] cnt,
                                          input logic       il);
    logic [1:0] r;
    if (il) r = start ^ cnt;
    else    r = start + cnt;
    return r;
  endfunction

endpackage

// File: rtl/nws_ctrl.sv
module nws_ctrl
  import nws_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load,
  input  logic              sel_ok,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              burst_il,
  input  logic [ADDR_W-1:0] addr,
  output op_e               op_q,
  output logic [ADDR_W-1:0] base_q,
  output logic              il_q,
  output logic [LANES-1:0]  lane_q
);

  op_e               op_d;
  logic [ADDR_W-1:0] base_d;
  logic              il_d;
  logic [LANES-1:0]  lane_d;

  always_comb begin
    op_d   = op_q;
    base_d = base_q;
    il_d   = il_q;
    lane_d = lane_q;
    if (en) begin
      lane_d = lane_wr_n;
      if (load) begin
        base_d = addr;
        il_d   = burst_il;
        if (!sel_ok)   op_d = OP_IDLE;
        else if (wr_n) op_d = OP_RD;
        else           op_d = OP_WR;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      il_q   <= 1'b0;
      lane_q <= '1;
    end else begin
      op_q   <= op_d;
      base_q <= base_d;
      il_q   <= il_d;
      lane_q <= lane_d;
    end
  end

endmodule

// File: rtl/nws_beat.sv
module nws_beat
  import nws_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       load,
  input  logic [1:0] start,
  input  logic       il,
  output logic [1:0] lsb
);

  logic [1:0] cnt_q;
  logic [1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      if (load) cnt_d = 2'd0;
      else      cnt_d = cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= 2'd0;
    else        cnt_q <= cnt_d;
  end

  assign lsb = beat_lsb(start, cnt_q, il);

endmodule

// File: rtl/nws_array.sv
module nws_array #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        lane_n,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANE_W*LANES-1:0] wdata,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANE_W*LANES-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    logic              lane_we;

    assign lane_we = wr_en && !lane_n[g];

    always_ff @(posedge clk) begin
      if (lane_we) store[wr_addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = store[rd_addr];
  end

endmodule

// File: rtl/nws_sram.sv
module nws_sram
  import nws_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en_n,
  input  logic                    sel0_n,
  input  logic                    sel1,
  input  logic                    sel2_n,
  input  logic                    advance,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    burst_il,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANE_W*LANES-1:0] wdata,
  output logic [LANE_W*LANES-1:0] rdata,
  output logic                    rdata_vld
);

  localparam int DW = LANE_W * LANES;

  logic              en;
  logic              load;
  logic              sel_ok;
  op_e               op_q;
  logic [ADDR_W-1:0] base_q;
  logic              il_q;
  logic [LANES-1:0]  lane_q;
  logic [1:0]        beat_lsb_w;
  logic [ADDR_W-1:0] eff_addr;
  logic [DW-1:0]     arr_rd;
  logic              wr_en;

  assign en     = !clk_en_n;
  assign load   = !advance;
  assign sel_ok = !sel0_n && sel1 && !sel2_n;

  nws_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .load      (load),
    .sel_ok    (sel_ok),
    .wr_n      (wr_n),
    .lane_wr_n (lane_wr_n),
    .burst_il  (burst_il),
    .addr      (addr),
    .op_q      (op_q),
    .base_q    (base_q),
    .il_q      (il_q),
    .lane_q    (lane_q)
  );

  nws_beat u_beat (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .load  (load),
    .start (base_q[1:0]),
    .il    (il_q),
    .lsb   (beat_lsb_w)
  );

  assign eff_addr = {base_q[ADDR_W-1:2], beat_lsb_w};

  // Write of the registered beat commits at the next enabled edge.
  assign wr_en = en && (op_q == OP_WR);

  nws_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk     (clk),
    .wr_en   (wr_en),
    .lane_n  (lane_q),
    .wr_addr (eff_addr),
    .wdata   (wdata),
    .rd_addr (eff_addr),
    .rdata   (arr_rd)
  );

  assign rdata_vld = (op_q == OP_RD);
  assign rdata     = rdata_vld ? arr_rd : '0;

endmodule

// File: rtl/nws_sram_chk.sv
module nws_sram_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en_n,
  input logic          sel0_n,
  input logic          sel1,
  input logic          sel2_n,
  input logic          advance,
  input logic          wr_n,
  input logic [DW-1:0] rdata,
  input logic          rdata_vld
);

  logic sel_all;
  assign sel_all = !sel0_n && sel1 && !sel2_n;

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_vld |-> (rdata == '0));

  assert_read_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !advance && sel_all && wr_n) |=> rdata_vld);

  assert_desel_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !advance && !sel_all) |=> !rdata_vld);

  assert_adv_keeps_op_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && advance) |=> (rdata_vld == $past(rdata_vld)));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(rdata_vld) && $stable(rdata)));

  assert_write_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !advance && sel_all && !wr_n) |=> !rdata_vld);

endmodule

bind nws_sram nws_sram_chk #(.DW(LANE_W*LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_en_n  (clk_en_n),
  .sel0_n    (sel0_n),
  .sel1      (sel1),
  .sel2_n    (sel2_n),
  .advance   (advance),
  .wr_n      (wr_n),
  .rdata     (rdata),
  .rdata_vld (rdata_vld)
);

// File: tb/sim_nws_sram.sv
`timescale 1ns/1ps
module sim_nws_sram;

  localparam int AW    = 8;
  localparam int LW    = 9;
  localparam int NL    = 2;
  localparam int DW    = LW * NL;
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] SEL = 3'b010; // {sel0_n, sel1, sel2_n}

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clk_en_n, sel0_n, sel1, sel2_n, advance, wr_n, burst_il;
  logic [NL-1:0] lane_wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          rdata_vld;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  nws_sram u0 (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel0_n(sel0_n),
    .sel1(sel1), .sel2_n(sel2_n), .advance(advance), .wr_n(wr_n),
    .lane_wr_n(lane_wr_n), .burst_il(burst_il), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_vld(rdata_vld)
  );

  // Behavioural reference model
  logic [DW-1:0] ref_mem [DEPTH];
  int            m_op;   // 0 none, 1 read, 2 write
  int            m_base;
  int            m_cnt;
  int            m_il;
  logic [NL-1:0] m_lane;

  function automatic logic [AW-1:0] m_addr();
    int lo;
    if (m_il != 0) lo = (m_base % 4) ^ m_cnt;
    else           lo = (m_base + m_cnt) % 4;
    return AW'((m_base / 4) * 4 + lo);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_op = 0; m_base = 0; m_cnt = 0; m_il = 0; m_lane = '1;
    end else if (!clk_en_n) begin
      if (m_op == 2) begin
        for (int l = 0; l < NL; l++)
          if (!m_lane[l]) ref_mem[m_addr()][l*LW +: LW] = wdata[l*LW +: LW];
      end
      if (!advance) begin
        if (!(!sel0_n && sel1 && !sel2_n)) m_op = 0;
        else if (wr_n)                      m_op = 1;
        else                                m_op = 2;
        m_base = int'(addr);
        m_cnt  = 0;
        m_il   = burst_il ? 1 : 0;
      end else begin
        m_cnt = (m_cnt + 1) % 4;
      end
      m_lane = lane_wr_n;
    end
  end

  task automatic check(input string tag);
    logic          ev;
    logic [DW-1:0] ed;
    ev = (m_op == 1);
    ed = ev ? ref_mem[m_addr()] : '0;
    n_tests++;
    if (rdata_vld !== ev || rdata !== ed) begin
      n_fail++;
      $display("FAIL %s: vld=%0b rdata=%05h expected vld=%0b rdata=%05h",
               tag, rdata_vld, rdata, ev, ed);
    end
  endtask

  task automatic cyc(input logic ck_n, input logic adv, input logic wn,
                     input logic [2:0] ce, input int a, input logic il,
                     input logic [NL-1:0] bw, input string tag);
    clk_en_n  = ck_n;
    advance   = adv;
    wr_n      = wn;
    {sel0_n, sel1, sel2_n} = ce;
    addr      = AW'(a);
    burst_il  = il;
    lane_wr_n = bw;
    wdata     = DW'($urandom);
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    clk_en_n = 1'b0; advance = 1'b0; wr_n = 1'b1;
    {sel0_n, sel1, sel2_n} = 3'b110;
    addr = '0; burst_il = 1'b0; lane_wr_n = '1; wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset");

    // R3 fill every word with linear write bursts
    for (int b = 0; b < DEPTH; b += 4) begin
      cyc(0, 0, 0, SEL, b, 0, 2'b00, "R3 fill load");
      for (int k = 0; k < 3; k++) cyc(0, 1, 0, SEL, 0, 0, 2'b00, "R5 fill beat");
    end
    cyc(0, 0, 1, 3'b110, 0, 0, 2'b11, "R4 deselect commit");

    // R6 linear and R7 interleaved read bursts from every start offset
    for (int s = 0; s < 16; s++) begin
      cyc(0, 0, 1, SEL, 64 + s, 0, 2'b11, "R6 linear load");
      for (int k = 0; k < 3; k++) cyc(0, 1, 1, SEL, 0, 0, 2'b11, "R6 linear beat");
      cyc(0, 0, 1, SEL, 128 + s, 1, 2'b11, "R7 interleaved load");
      for (int k = 0; k < 3; k++) cyc(0, 1, 1, SEL, 0, 0, 2'b11, "R7 interleaved beat");
    end

    // R7 interleaved write burst, read back linearly
    cyc(0, 0, 0, SEL, 201, 1, 2'b00, "R7 il write load");
    for (int k = 0; k < 3; k++) cyc(0, 1, 0, SEL, 0, 1, 2'b00, "R7 il write beat");
    cyc(0, 0, 1, SEL, 200, 0, 2'b11, "R7 readback load");
    for (int k = 0; k < 3; k++) cyc(0, 1, 1, SEL, 0, 0, 2'b11, "R7 readback beat");

    // R9 alternating reads and writes; R10 read right after write of same word
    for (int i = 0; i < 40; i++) begin
      int a = int'($urandom % DEPTH);
      cyc(0, 0, 0, SEL, a, 0, 2'b00, "R9 alt write");
      cyc(0, 0, 1, SEL, a, 0, 2'b11, "R10 read after write");
      cyc(0, 0, 1, SEL, int'($urandom % DEPTH), 0, 2'b11, "R9 alt read");
    end

    // R3 partial lane writes
    for (int i = 0; i < 16; i++) begin
      int a = int'($urandom % DEPTH);
      cyc(0, 0, 0, SEL, a, 0, NL'(i % 4), "R3 lane write");
      cyc(0, 0, 1, SEL, a, 0, 2'b11, "R3 lane readback");
    end

    // R4 / R11 deselect variants, including advance after deselect
    for (int v = 0; v < 3; v++) begin
      logic [2:0] bad;
      bad = (v == 0) ? 3'b110 : (v == 1) ? 3'b000 : 3'b011;
      cyc(0, 0, 0, bad, 12, 0, 2'b00, "R4 deselect write attempt");
      cyc(0, 1, 0, bad, 0, 0, 2'b00, "R4 advance while deselected");
      cyc(0, 0, 1, bad, 12, 0, 2'b11, "R11 deselect read attempt");
      cyc(0, 0, 1, SEL, 12, 0, 2'b11, "R4 word unchanged");
    end

    // R8 stalls: during a read, during a pending write, inside a burst
    cyc(0, 0, 1, SEL, 33, 0, 2'b11, "R8 read before stall");
    for (int k = 0; k < 3; k++) cyc(1, 0, 0, 3'b110, 99, 1, 2'b00, "R8 stall on read");
    cyc(0, 0, 0, SEL, 34, 0, 2'b00, "R8 write load");
    for (int k = 0; k < 3; k++) cyc(1, 1, 1, SEL, 7, 0, 2'b11, "R8 stall pending write");
    cyc(0, 0, 1, SEL, 34, 0, 2'b11, "R8 readback after stall");
    cyc(0, 1, 1, SEL, 0, 0, 2'b11, "R8 burst beat");
    cyc(1, 0, 0, SEL, 0, 0, 2'b00, "R8 stall in burst");
    cyc(0, 1, 1, SEL, 0, 0, 2'b11, "R8 burst resumes");

    // R5 random mix of everything
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] ce;
      ce = ($urandom % 8 == 0) ? 3'($urandom) : SEL;
      cyc(($urandom % 8) == 0, $urandom % 2 == 1, $urandom % 2 == 1, ce,
          int'($urandom % DEPTH), $urandom % 2 == 1, NL'($urandom), "R5 random mix");
    end

    finish_run();
  end

endmodule